// File: doc/BRIEF.md
# Bit-Slice Mode-Selectable Logic and Arithmetic Unit

This block is a purely combinational N-bit unit made from one repeated bit cell. A two-bit select and a mode bit choose the function. In logic mode every bit of the result depends only on the two operand bits in the same position, and the carry plays no part. In arithmetic mode the cells form a ripple-carry adder whose operands are conditioned by the select bits, so a few extra functions come from the same cell without any further logic: increment, negation, and B minus A.

The select bits act independently inside each cell. The low select bit inverts the A operand bit before use. The high select bit lets the B operand bit through; when it is clear, B is forced to zero. The mode bit gates the rippling carry. A datapath instantiates the unit with the width it needs, drives both operands, the select, the mode and the carry-in, and reads the result and the carry from the top cell in the same cycle.

Top module: `mode_alu`

## Requirements
- R1: With mode_i=0 and sel_i=2'b00 (sel_i[1] is the B-enable select, sel_i[0] the A-invert select), f_o equals a_i.
- R2: With mode_i=0 and sel_i=2'b01, f_o equals the bitwise complement of a_i.
- R3: With mode_i=0 and sel_i=2'b10, f_o equals a_i XOR b_i.
- R4: With mode_i=0 and sel_i=2'b11, f_o equals the bitwise XNOR of a_i and b_i.
- R5: With mode_i=0, cin_i has no effect on f_o.
- R6: With mode_i=0, cout_o is 0 for every operand, select and carry-in value.
- R7: With mode_i=1 and sel_i[1]=0, b_i has no effect: {cout_o,f_o} equals a_i+cin_i when sel_i[0]=0 and (NOT a_i)+cin_i when sel_i[0]=1, so cin_i=1 gives increment and the two's complement of a_i.
- R8: With mode_i=1 and sel_i=2'b10, {cout_o,f_o} equals the (WIDTH+1)-bit sum a_i+b_i+cin_i.
- R9: With mode_i=1 and sel_i=2'b11, {cout_o,f_o} equals (NOT a_i)+b_i+cin_i; with cin_i=1, f_o equals b_i minus a_i modulo 2^WIDTH.
- R10: In arithmetic mode cout_o is the carry out of the most significant cell, and it is 1 exactly when the conditioned operand sum plus cin_i reaches 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand, gated by sel_i[1] |
| sel_i | input | 2 | Function select: bit 1 enables B, bit 0 inverts A |
| mode_i | input | 1 | 0 selects logic mode, 1 selects arithmetic mode |
| cin_i | input | 1 | Carry into the least significant cell |
| f_o | output | WIDTH | Result |
| cout_o | output | 1 | Carry out of the most significant cell, 0 in logic mode |

## Verification
The bench sweeps every operand pair, select, mode and carry-in on a 4-bit build and computes each expected value from integer arithmetic. It watches the all-ones and zero operands, where a carry entering through cin_i must ripple across every cell: a cell with a broken carry term would give a wrong increment of all-ones or a wrong negation of zero. In logic mode it flips cin_i with the operands held, so a design that forgot to gate the carry would turn XOR into a sum and raise cout_o. With sel_i[1] clear it varies b_i alone, and a cell that did not block B would let b_i leak into the increment and negate results.

// File: rtl/mode_alu_pkg.sv
package mode_alu_pkg;

    typedef enum logic [1:0] {
        SEL_PASS_A = 2'b00,
        SEL_INV_A  = 2'b01,
        SEL_A_B    = 2'b10,
        SEL_NA_B   = 2'b11
    } alu_sel_e;

    typedef struct packed {
        logic inv_a;
        logic use_b;
        logic arith;
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_ctrl(input logic [1:0] sel, input logic mode);
        alu_ctrl_t c;
        c.inv_a = sel[0];
        c.use_b = sel[1];
        c.arith = mode;
        return c;
    endfunction

endpackage

// File: rtl/mode_alu_opnd.sv
module mode_alu_opnd
    import mode_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_raw,
    input  logic [WIDTH-1:0] b_raw,
    input  alu_ctrl_t        ctrl,
    output logic [WIDTH-1:0] a_cond,
    output logic [WIDTH-1:0] b_cond
);

    always_comb begin
        a_cond = a_raw ^ {WIDTH{ctrl.inv_a}};
        b_cond = b_raw & {WIDTH{ctrl.use_b}};
    end

endmodule

// File: rtl/mode_alu_cell.sv
module mode_alu_cell (
    input  logic op_a,
    input  logic op_b,
    input  logic arith,
    input  logic c_in,
    output logic f_bit,
    output logic c_out
);

    logic half_sum;
    logic c_gated;

    always_comb begin
        half_sum = op_a ^ op_b;
        c_gated  = c_in & arith;
        f_bit    = half_sum ^ c_gated;
        c_out    = arith & ((op_a & op_b) | (c_gated & half_sum));
    end

endmodule

// File: rtl/mode_alu.sv
module mode_alu
    import mode_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       sel_i,
    input  logic             mode_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] f_o,
    output logic             cout_o
);

    localparam int NCARRY = WIDTH + 1;

    alu_ctrl_t         ctrl;
    logic [WIDTH-1:0]  a_cond;
    logic [WIDTH-1:0]  b_cond;
    logic [NCARRY-1:0] carry;

    assign ctrl     = decode_ctrl(sel_i, mode_i);
    assign carry[0] = cin_i;

    mode_alu_opnd #(.WIDTH(WIDTH)) opnd_i (
        .a_raw  (a_i),
        .b_raw  (b_i),
        .ctrl   (ctrl),
        .a_cond (a_cond),
        .b_cond (b_cond)
    );

    for (genvar k = 0; k < WIDTH; k++) begin : g_cell
        mode_alu_cell cell_i (
            .op_a  (a_cond[k]),
            .op_b  (b_cond[k]),
            .arith (ctrl.arith),
            .c_in  (carry[k]),
            .f_bit (f_o[k]),
            .c_out (carry[k+1])
        );
    end

    assign cout_o = carry[NCARRY-1];

endmodule

// File: rtl/mode_alu_chk.sv
module mode_alu_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [1:0]       sel_i,
    input logic             mode_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] f_o,
    input logic             cout_o
);

    logic [WIDTH:0] ref_sum;
    logic           known;

    always_comb begin
        known   = !$isunknown({a_i, b_i, sel_i, mode_i, cin_i, f_o, cout_o});
        ref_sum = {1'b0, (sel_i[0] ? ~a_i : a_i)}
                + {1'b0, (sel_i[1] ? b_i : {WIDTH{1'b0}})}
                + {{WIDTH{1'b0}}, cin_i};
        if (known) begin
            a_r6_logic_cout_zero: assert (mode_i || !cout_o)
                else $error("R6 carry out raised in logic mode");
            a_r3_logic_xor: assert (mode_i || sel_i != 2'b10 || f_o == (a_i ^ b_i))
                else $error("R3 logic xor mismatch");
            a_r4_logic_xnor: assert (mode_i || sel_i != 2'b11 || f_o == ~(a_i ^ b_i))
                else $error("R4 logic xnor mismatch");
            a_r7_b_blocked: assert (!mode_i || sel_i[1] || f_o == ref_sum[WIDTH-1:0])
                else $error("R7 B leaked into A-only arithmetic");
            a_r10_arith_sum: assert (!mode_i || {cout_o, f_o} == ref_sum)
                else $error("R10 arithmetic sum or carry mismatch");
        end
    end

endmodule

bind mode_alu mode_alu_chk #(.WIDTH(WIDTH)) chk_i (
    .a_i    (a_i),
    .b_i    (b_i),
    .sel_i  (sel_i),
    .mode_i (mode_i),
    .cin_i  (cin_i),
    .f_o    (f_o),
    .cout_o (cout_o)
);

// File: tb/mode_alu_tb_top.sv
module mode_alu_tb_top;

    localparam int W    = 4;
    localparam int SPAN = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a, b, f;
    logic [1:0]   sel;
    logic         mode, cin, cout;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           done  = 0;

    always #2.5 clk = ~clk;

    mode_alu #(.WIDTH(W)) dut_i (
        .a_i(a), .b_i(b), .sel_i(sel), .mode_i(mode), .cin_i(cin),
        .f_o(f), .cout_o(cout)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s a=%0d b=%0d sel=%0d m=%0d c=%0d actual=%0d expected=%0d",
                     req, a, b, sel, mode, cin, act, exp);
        end
    endtask

    task automatic apply(input int av, input int bv, input int s, input int m, input int c);
        @(negedge clk);
        a = av[W-1:0]; b = bv[W-1:0]; sel = s[1:0]; mode = m[0]; cin = c[0];
        #1;
    endtask

    function automatic int expect_val(input int av, input int bv, input int s, input int m, input int c);
        int na = (SPAN - 1) - av;
        int opa = (s & 1) ? na : av;
        int opb = (s & 2) ? bv : 0;
        if (m == 0) begin
            case (s)
                0: return av;
                1: return na;
                2: return av ^ bv;
                default: return (SPAN - 1) - (av ^ bv);
            endcase
        end
        return opa + opb + c;
    endfunction

    initial begin
        a = '0; b = '0; sel = '0; mode = 1'b0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset-time state: all-zero inputs in logic mode give zero result
        apply(0, 0, 0, 0, 0);
        check("R1", f, 0);
        check("R6", cout, 0);

        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++)
                for (int c = 0; c < 2; c++)
                    for (int av = 0; av < SPAN; av++)
                        for (int bv = 0; bv < SPAN; bv++) begin
                            string tag;
                            int e;
                            apply(av, bv, s, m, c);
                            e = expect_val(av, bv, s, m, c);
                            if (m == 0) begin
                                tag = (s == 0) ? "R1" : (s == 1) ? "R2" : (s == 2) ? "R3" : "R4";
                                check(tag, f, e);
                                check("R6", cout, 0);
                            end else begin
                                tag = (s < 2) ? "R7" : (s == 2) ? "R8" : "R9";
                                check(tag, f, e % SPAN);
                                check("R10", cout, e / SPAN);
                            end
                        end

        // R5: toggle cin in logic mode with operands held
        for (int s = 0; s < 4; s++) begin
            int f0;
            apply(9, 5, s, 0, 0);
            f0 = f;
            apply(9, 5, s, 0, 1);
            check("R5", f, f0);
        end
        // R7: vary b alone with B blocked
        for (int bv = 0; bv < SPAN; bv++) begin
            apply(SPAN - 1, bv, 0, 1, 1);
            check("R7", f, 0);
            check("R7", cout, 1);
            apply(0, bv, 1, 1, 1);
            check("R7", f, 0);
        end
        // R9: B minus A
        apply(3, 10, 3, 1, 1);
        check("R9", f, 7);
        apply(10, 3, 3, 1, 1);
        check("R9", f, (3 - 10 + SPAN) % SPAN);
        // R8: full ripple
        apply(SPAN - 1, 0, 2, 1, 1);
        check("R8", f, 0);
        check("R10", cout, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule